// File: doc/BRIEF.md
# Shared SDRAM Bus Handoff Sequencer

This block decides who owns an external bus that carries an SDRAM and is shared between the local processor cluster and an outside host. After reset it keeps the bus with the local side but blocks all local SDRAM traffic. The block waits until the initialising master signals that the memory is configured. Once that has happened, local agents may use the SDRAM until the host asks for the bus.

A host request is not granted at once. The block first asks the local memory controller to put the SDRAM into self-refresh. It gives the grant only after that controller acknowledges the command. While the host holds the bus, the block follows the host's own mode commands: leaving self-refresh for normal work, and going back into self-refresh. This tells it what state the memory is in when the host lets go.

A release with the memory in self-refresh returns control to the local side after one check cycle. A release with the memory left in normal mode sets a sticky protocol-error flag. In that case the block issues the self-refresh command itself and waits for its acknowledgement before local access resumes.

Top module: `shared_bus_handoff`

## Requirements
- R1: After reset all four outputs are low. A host request is not granted and no self-refresh command is raised until `init_done_i` is sampled high. The cycle after that sample, `local_en_o` is high.
- R2: A host request sampled while the local side owns the bus raises `sr_cmd_o` and drops `local_en_o` in the next cycle, with `host_grant_o` still low. `sr_cmd_o` stays high until `sr_ack_i` is sampled.
- R3: `host_grant_o` rises in the cycle after `sr_ack_i` is sampled with `sr_cmd_o` high, and `sr_cmd_o` falls in that same cycle.
- R4: While the host is granted, `host_sr_exit_i` marks the memory as normal and `host_sr_enter_i` marks it as self-refresh; enter wins when both are high. The grant stays high through these commands.
- R5: A release (`host_rel_i`) with the memory marked self-refresh drops the grant in the next cycle. One cycle follows with grant, local enable and self-refresh command all low, and then `local_en_o` is high.
- R6: A release with the memory marked normal sets `proto_err_o` in the next cycle, and it stays high until reset. `sr_cmd_o` is raised together with it and is held until `sr_ack_i`. `local_en_o` rises in the cycle after that acknowledgement.
- R7: `local_en_o` is high only while the local side owns the bus with the memory released to it, and never together with `host_grant_o`.
- R8: The following inputs change no output: `sr_ack_i` while `sr_cmd_o` is low, host mode commands or `host_rel_i` while the host is not granted, and `init_done_i` after initialisation.
- R9: A release sampled together with `host_sr_enter_i` counts as a clean release (R5) and raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | Strobe: the initialising master has configured the SDRAM |
| host_req_i | input | 1 | Host bus request, level, held until granted |
| host_rel_i | input | 1 | Strobe: host gives the bus back |
| sr_ack_i | input | 1 | Local memory controller has issued the self-refresh entry command |
| host_sr_exit_i | input | 1 | Strobe: host issued a self-refresh exit command |
| host_sr_enter_i | input | 1 | Strobe: host issued a self-refresh entry command |
| host_grant_o | output | 1 | Bus granted to the host (registered) |
| sr_cmd_o | output | 1 | Request to the local controller to enter self-refresh |
| local_en_o | output | 1 | Local agents may access the SDRAM |
| proto_err_o | output | 1 | Sticky: host released the bus with SDRAM not in self-refresh |

## Verification
The assertions assume that `host_req_i` is held until the grant and then dropped no later than the release. They also assume that `sr_ack_i` and the host strobes last one cycle each. The bench drives every input as a full vector for one cycle at a time and follows these rules for all legal traffic. Stray strobes are placed on purpose only in states where R8 says they are ignored. With that stimulus, a rising grant can only follow an acknowledged self-refresh command, and a return to local ownership can only happen with the memory known to be in self-refresh.

// File: rtl/hsq_pkg.sv
package hsq_pkg;

  typedef enum logic [2:0] {
    ST_UNINIT    = 3'd0,
    ST_LOCAL     = 3'd1,
    ST_ENTER_SR  = 3'd2,
    ST_HOST_SR   = 3'd3,
    ST_HOST_NORM = 3'd4,
    ST_RETURN    = 3'd5
  } hsq_state_e;

  // The host is the bus owner in these states.
  function automatic logic is_host(hsq_state_e s);
    return (s == ST_HOST_SR) || (s == ST_HOST_NORM);
  endfunction

  // Next value of the "memory is in self-refresh" flag.
  function automatic logic mode_next(logic sr_now, logic host_active,
                                     logic exit_c, logic enter_c,
                                     logic local_done);
    if (local_done)                return 1'b1;
    else if (host_active && enter_c) return 1'b1;
    else if (host_active && exit_c)  return 1'b0;
    else                             return sr_now;
  endfunction

endpackage

// File: rtl/hsq_mode_track.sv
module hsq_mode_track (
  input  logic clk,
  input  logic rst_n,
  input  logic host_active,
  input  logic host_exit,
  input  logic host_enter,
  input  logic local_done,
  output logic sr_q,
  output logic sr_d
);
  import hsq_pkg::*;

  assign sr_d = mode_next(sr_q, host_active, host_exit, host_enter, local_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 1'b0;
    else        sr_q <= sr_d;
  end

  // R4: with the host inactive and no local completion, the flag holds
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_active && !local_done) |=> $stable(sr_q));

endmodule

// File: rtl/hsq_fsm.sv
module hsq_fsm
  import hsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_done,
  input  logic       host_req,
  input  logic       host_rel,
  input  logic       sr_ack,
  input  logic       sr_mode_q,
  input  logic       sr_mode_d,
  output hsq_state_e state_q,
  output hsq_state_e state_d,
  output logic       sr_cmd_req,
  output logic       local_en
);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_UNINIT:    if (init_done) state_d = ST_LOCAL;
      ST_LOCAL:     if (host_req)  state_d = ST_ENTER_SR;
      ST_ENTER_SR:  if (sr_ack)    state_d = ST_HOST_SR;
      ST_HOST_SR,
      ST_HOST_NORM: begin
        if (host_rel)       state_d = ST_RETURN;
        else if (sr_mode_d) state_d = ST_HOST_SR;
        else                state_d = ST_HOST_NORM;
      end
      ST_RETURN:    if (sr_mode_q || sr_ack) state_d = ST_LOCAL;
      default:      state_d = ST_UNINIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_UNINIT;
    else        state_q <= state_d;
  end

  assign sr_cmd_req = (state_q == ST_ENTER_SR) ||
                      ((state_q == ST_RETURN) && !sr_mode_q);
  assign local_en   = (state_q == ST_LOCAL);

  wire back_to_local = (state_q == ST_RETURN) && (state_d == ST_LOCAL);

  // R1: without init_done the block never leaves the uninitialised state
  a_r1_hold_uninit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNINIT && !init_done) |=> (state_q == ST_UNINIT));

  // R2: the self-refresh request is held until acknowledged
  a_r2_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_cmd_req && !sr_ack) |=> sr_cmd_req);

  // R5: local ownership resumes only with the memory in self-refresh
  a_r5_return_sr: assert property (@(posedge clk) disable iff (!rst_n)
    back_to_local |-> (sr_mode_q || sr_ack));

endmodule

// File: rtl/hsq_grant_err.sv
module hsq_grant_err
  import hsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  hsq_state_e state_q,
  input  hsq_state_e state_d,
  input  logic       host_rel,
  input  logic       sr_mode_d,
  output logic       grant_q,
  output logic       err_q
);

  wire dirty_release = is_host(state_q) && host_rel && !sr_mode_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      grant_q <= is_host(state_d);
      err_q   <= err_q | dirty_release;
    end
  end

  // R6: the protocol error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R6: a dirty release always raises the flag
  a_r6_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_release |=> err_q);

endmodule

// File: rtl/shared_bus_handoff.sv
module shared_bus_handoff
  import hsq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init_done_i,
  input  logic host_req_i,
  input  logic host_rel_i,
  input  logic sr_ack_i,
  input  logic host_sr_exit_i,
  input  logic host_sr_enter_i,
  output logic host_grant_o,
  output logic sr_cmd_o,
  output logic local_en_o,
  output logic proto_err_o
);

  hsq_state_e state_q;
  hsq_state_e state_d;
  logic       sr_mode_q;
  logic       sr_mode_d;
  logic       sr_cmd_req;

  wire sr_done     = sr_cmd_req && sr_ack_i;
  wire host_active = is_host(state_q);

  hsq_mode_track u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_active (host_active),
    .host_exit   (host_sr_exit_i),
    .host_enter  (host_sr_enter_i),
    .local_done  (sr_done),
    .sr_q        (sr_mode_q),
    .sr_d        (sr_mode_d)
  );

  hsq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_done  (init_done_i),
    .host_req   (host_req_i),
    .host_rel   (host_rel_i),
    .sr_ack     (sr_ack_i),
    .sr_mode_q  (sr_mode_q),
    .sr_mode_d  (sr_mode_d),
    .state_q    (state_q),
    .state_d    (state_d),
    .sr_cmd_req (sr_cmd_req),
    .local_en   (local_en_o)
  );

  hsq_grant_err u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .state_d   (state_d),
    .host_rel  (host_rel_i),
    .sr_mode_d (sr_mode_d),
    .grant_q   (host_grant_o),
    .err_q     (proto_err_o)
  );

  assign sr_cmd_o = sr_cmd_req;

  // R3: a grant edge follows an acknowledged self-refresh command
  a_r3_grant_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_grant_o) |-> $past(sr_cmd_o && sr_ack_i));

  // R7: local access and host grant are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    local_en_o |-> !host_grant_o);

  // R3: the grant and the self-refresh command never overlap
  a_r3_no_cmd_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant_o |-> !sr_cmd_o);

endmodule

// File: tb/shared_bus_handoff_bench.sv
module shared_bus_handoff_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_done_i = 0, host_req_i = 0, host_rel_i = 0;
  logic sr_ack_i = 0, host_sr_exit_i = 0, host_sr_enter_i = 0;
  logic host_grant_o, sr_cmd_o, local_en_o, proto_err_o;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_bus_handoff u_shared_bus_handoff (
    .clk(clk), .rst_n(rst_n),
    .init_done_i(init_done_i), .host_req_i(host_req_i), .host_rel_i(host_rel_i),
    .sr_ack_i(sr_ack_i), .host_sr_exit_i(host_sr_exit_i),
    .host_sr_enter_i(host_sr_enter_i),
    .host_grant_o(host_grant_o), .sr_cmd_o(sr_cmd_o),
    .local_en_o(local_en_o), .proto_err_o(proto_err_o)
  );

  function automatic logic [3:0] outs();
    return {host_grant_o, sr_cmd_o, local_en_o, proto_err_o};
  endfunction

  task automatic check(logic [3:0] exp, string tag);
    n_run++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: {grant,sr_cmd,local_en,err} got %b expected %b",
               tag, outs(), exp);
    end
  endtask

  // Driver: one input vector {init,req,rel,ack,exit,enter} per cycle,
  // expected outputs after the following rising edge.
  task automatic step(logic [5:0] vin, logic [3:0] exp, string tag);
    @(negedge clk);
    {init_done_i, host_req_i, host_rel_i, sr_ack_i,
     host_sr_exit_i, host_sr_enter_i} = vin;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(e, t);
    end
  end

  localparam logic [5:0] NONE = 6'b000000, INIT = 6'b100000, REQ = 6'b010000,
                         REL  = 6'b001000, ACK  = 6'b000100, EXIT = 6'b000010,
                         ENT  = 6'b000001;

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(4'b0000, "R1 reset state");
    step(REQ,              4'b0000, "R1 request held before init");
    step(REQ | ACK,        4'b0000, "R8 stray ack before init");
    step(INIT | REQ,       4'b0010, "R1 init_done gives local ownership");
    step(REQ,              4'b0100, "R2 self-refresh requested");
    step(REQ,              4'b0100, "R2 request held without ack");
    step(REQ | ACK,        4'b1000, "R3 grant after ack");
    step(EXIT,             4'b1000, "R4 host exits self-refresh");
    step(ENT,              4'b1000, "R4 host enters self-refresh");
    step(REL,              4'b0000, "R5 return check cycle");
    step(NONE,             4'b0010, "R7 local access resumes");
    step(INIT | REL | ACK | EXIT | ENT, 4'b0010, "R8 ignored while local");
    step(REQ,              4'b0100, "R2 second request");
    step(ACK,              4'b1000, "R3 second grant");
    step(EXIT,             4'b1000, "R4 normal mode in host");
    step(REL,              4'b0101, "R6 dirty release flags error");
    step(NONE,             4'b0101, "R6 self-refresh held until ack");
    step(ACK,              4'b0011, "R6 local after ack");
    step(NONE,             4'b0011, "R6 error sticky");
    step(REQ,              4'b0101, "R2 third request");
    step(ACK,              4'b1001, "R3 third grant");
    step(EXIT,             4'b1001, "R4 host normal again");
    step(REL | ENT,        4'b0001, "R9 release with enter is clean");
    step(NONE,             4'b0011, "R9 local resumes");
    step(REQ,              4'b0101, "R2 fourth request");
    step(REL | EXIT,       4'b0101, "R8 release ignored before grant");
    step(ACK,              4'b1001, "R3 fourth grant");
    step(REL,              4'b0001, "R5 clean release");
    step(NONE,             4'b0011, "R7 local again");
    step(NONE,             4'b0011, "R6 error still held");
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule